// File: doc/BRIEF.md
# PWM channel enable and interrupt controller

This block is the shared control plane of a multi-channel pulse-width modulator, four channels by default. It holds the run state of every channel and the interrupt mask. Software changes both only through paired set and clear strobes: a one in a bit acts on that channel, and a zero leaves it as it was. The block also exposes read-only views of the run state and of the mask, and a mode word for the clock generator next to it.

Each channel counter sends a one-cycle pulse at the end of each period. The block latches these pulses as pending events. Reading the event register returns the pending events and clears them. The interrupt line is the registered OR of the pending events that the mask lets through. The channel counters, the clock dividers and any bus bridge sit outside this block.

Top module: `pwm_ctl_plane`

## Requirements
- R1: A write to byte offset 0x04 sets every channel-run bit whose write-data bit is 1, and leaves every other run bit unchanged. `chan_run` shows the new state one cycle after the write.
- R2: A write to offset 0x08 clears every run bit whose write-data bit is 1. Writing all ones stops every channel.
- R3: A read of offset 0x0C returns the run state in bits [NCH-1:0]. Bit n is 1 exactly while channel n runs, and the upper bits are 0.
- R4: Writes to offset 0x10 set mask bits and writes to 0x14 clear mask bits, each in the write-one manner. A read of 0x18 returns the current mask.
- R5: A pulse on `period_end[n]` makes event bit n pending. A read of offset 0x1C returns the pending events and clears them, so a second read returns 0.
- R6: An event pulse that arrives in the same cycle as a read of 0x1C is not returned by that read. It stays pending and is returned by the next read.
- R7: `irq` is active high. It goes to 1 one cycle after a pending event meets a set mask bit, and stays 0 while no pending event is unmasked.
- R8: Reset clears the run state, the mask, the pending events, `irq`, the mode word and `bus_rdata`.
- R9: Offset 0x00 is a read/write mode word of DW bits. It drives `mode_cfg` and reads back what was last written.
- R10: Writes to the read-only offsets 0x0C, 0x18 and 0x1C change nothing. Reads of the write-only offsets 0x04, 0x08, 0x10 and 0x14 return 0. An access with nonzero address bits [1:0] reaches no register.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| period_end | input | NCH | End-of-period pulse per channel |
| chan_run | output | NCH | Channel run state |
| mode_cfg | output | DW | Mode word for the clock generator |
| irq | output | 1 | Combined interrupt, registered, active high |

## Verification
A wrong run bit shows on `chan_run` in the cycle after the offending write, and it shows again in the status read. A corrupted mask stays hidden until a matching event arrives: `irq` then misbehaves one cycle later, or the mask read-back shows it. A bad pending-event bit shows on `irq` or on the next event read. The same-cycle read-and-pulse case is the one where a lost event shows only on the second read, so the bench reads twice after it.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
   // word index = byte offset / 4
   typedef enum logic [2:0] {
      IDX_MODE  = 3'd0,
      IDX_ENA   = 3'd1,
      IDX_DIS   = 3'd2,
      IDX_STAT  = 3'd3,
      IDX_IEN   = 3'd4,
      IDX_IDIS  = 3'd5,
      IDX_IMASK = 3'd6,
      IDX_ISR   = 3'd7
   } reg_idx_e;

   localparam int NUM_REGS = 8;
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
   import pwm_ctl_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_REGS-1:0] wr_stb_o,
   output logic [NUM_REGS-1:0] rd_stb_o
);
   logic hit;

   generate
      if (ADDR_W > 5) begin : g_upper
         assign hit = sel_i && (addr_i[ADDR_W-1:5] == '0) && (addr_i[1:0] == 2'b00);
      end else begin : g_exact
         assign hit = sel_i && (addr_i[1:0] == 2'b00);
      end
   endgenerate

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_stb
      assign wr_stb_o[r] = hit &&  wr_i && (addr_i[4:2] == r[2:0]);
      assign rd_stb_o[r] = hit && !wr_i && (addr_i[4:2] == r[2:0]);
   end
endmodule

// File: rtl/pwm_setclr_reg.sv
module pwm_setclr_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)         q_o[b] <= 1'b0;
         else if (clr_i[b])  q_o[b] <= 1'b0;
         else if (set_i[b])  q_o[b] <= 1'b1;
      end
   end
endmodule

// File: rtl/pwm_evt_latch.sv
module pwm_evt_latch #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pulse_i,
   input  logic         ack_i,
   output logic [W-1:0] pend_o
);
   // ack clears what was visible this cycle; a pulse in the same cycle survives
   for (genvar b = 0; b < W; b++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n)      pend_o[b] <= 1'b0;
         else if (ack_i)  pend_o[b] <= pulse_i[b];
         else             pend_o[b] <= pend_o[b] | pulse_i[b];
      end
   end
endmodule

// File: rtl/pwm_ctl_plane.sv
module pwm_ctl_plane
   import pwm_ctl_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DW     = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NCH-1:0]    period_end,
   output logic [NCH-1:0]    chan_run,
   output logic [DW-1:0]     mode_cfg,
   output logic              irq
);
   if (NCH < 1 || NCH > DW) begin : g_bad_nch
      $error("pwm_ctl_plane: NCH must lie in 1..DW");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pwm_ctl_plane: ADDR_W must be at least 5");
   end

   logic [NUM_REGS-1:0] wr_stb, rd_stb;
   logic [NCH-1:0]      mask_q, ev_q, wd_ch;
   logic [DW-1:0]       rd_mux;

   assign wd_ch = bus_wdata[NCH-1:0];

   pwm_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel_i    (bus_sel),
      .wr_i     (bus_wr),
      .addr_i   (bus_addr),
      .wr_stb_o (wr_stb),
      .rd_stb_o (rd_stb)
   );

   pwm_setclr_reg #(.W(NCH)) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_stb[IDX_ENA] ? wd_ch : '0),
      .clr_i (wr_stb[IDX_DIS] ? wd_ch : '0),
      .q_o   (chan_run)
   );

   pwm_setclr_reg #(.W(NCH)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_stb[IDX_IEN]  ? wd_ch : '0),
      .clr_i (wr_stb[IDX_IDIS] ? wd_ch : '0),
      .q_o   (mask_q)
   );

   pwm_evt_latch #(.W(NCH)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pulse_i(period_end),
      .ack_i  (rd_stb[IDX_ISR]),
      .pend_o (ev_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 mode_cfg <= '0;
      else if (wr_stb[IDX_MODE])  mode_cfg <= bus_wdata;
   end

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         rd_stb[IDX_MODE]:  rd_mux = mode_cfg;
         rd_stb[IDX_STAT]:  rd_mux[NCH-1:0] = chan_run;
         rd_stb[IDX_IMASK]: rd_mux[NCH-1:0] = mask_q;
         rd_stb[IDX_ISR]:   rd_mux[NCH-1:0] = ev_q;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          bus_rdata <= '0;
      else if (|rd_stb)    bus_rdata <= rd_mux;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(ev_q & mask_q);
   end
endmodule

// File: rtl/pwm_ctl_plane_chk.sv
module pwm_ctl_plane_chk #(
   parameter int NCH    = 4,
   parameter int DW     = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DW-1:0]     bus_wdata,
   input logic [NCH-1:0]    period_end,
   input logic [NCH-1:0]    chan_run,
   input logic [NCH-1:0]    ev_q,
   input logic [NCH-1:0]    mask_q,
   input logic              irq
);
   logic wr_ena, wr_dis;
   assign wr_ena = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));
   assign wr_dis = bus_sel && bus_wr && (bus_addr == ADDR_W'(8));

   assert_enable_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ena |=> ((chan_run & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

   assert_run_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ena && !wr_dis) |=> $stable(chan_run));

   assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dis |=> ((chan_run & $past(bus_wdata[NCH-1:0])) == '0));

   assert_event_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end != '0) |=> ((ev_q & $past(period_end)) == $past(period_end)));

   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_q & mask_q) == '0) |=> !irq);

   assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_q & mask_q) != '0) |=> irq);
endmodule

bind pwm_ctl_plane pwm_ctl_plane_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .period_end (period_end),
   .chan_run   (chan_run),
   .ev_q       (ev_q),
   .mask_q     (mask_q),
   .irq        (irq)
);

// File: tb/pwm_ctl_plane_test.sv
module pwm_ctl_plane_test;
   localparam int NCH = 4, DW = 32, AW = 5;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic [NCH-1:0] period_end = '0, chan_run;
   logic [DW-1:0] mode_cfg;
   logic          irq;

   int checks = 0, failures = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          rd_seen = 1'b0;

   always #5 clk = ~clk;

   pwm_ctl_plane #(.NCH(NCH), .DW(DW), .ADDR_W(AW)) uut (.*);

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: a read sampled at a posedge has its data checked at the next negedge
   always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) check("R11 unexpected read", bus_rdata, '0);
         else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   // driver tasks start and end at a falling edge
   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string tag, logic [NCH-1:0] p = '0);
      exp_q.push_back(e); tag_q.push_back(tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; period_end = p;
      @(negedge clk);
      bus_sel = 1'b0; period_end = '0;
   endtask

   task automatic pulse(logic [NCH-1:0] p);
      period_end = p;
      @(negedge clk);
      period_end = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(10 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      check("R8 run after reset", DW'(chan_run), '0);
      check("R8 irq after reset", DW'(irq), '0);
      check("R8 rdata after reset", bus_rdata, '0);
      rd(5'h0C, 32'h0, "R8 status after reset");
      rd(5'h18, 32'h0, "R8 mask after reset");
      rd(5'h1C, 32'h0, "R8 events after reset");

      wr(5'h04, 32'h5);
      check("R1 enable 0101", DW'(chan_run), 32'h5);
      wr(5'h04, 32'h2);
      check("R1 zero bits keep", DW'(chan_run), 32'h7);
      rd(5'h0C, 32'h7, "R3 status 0111");
      wr(5'h08, 32'h1);
      check("R2 disable bit0", DW'(chan_run), 32'h6);
      rd(5'h0C, 32'h6, "R3 status 0110");
      wr(5'h08, 32'hFFFF_FFFF);
      check("R2 disable all", DW'(chan_run), 32'h0);

      wr(5'h10, 32'h9);
      rd(5'h18, 32'h9, "R4 mask set 1001");
      wr(5'h14, 32'h1);
      rd(5'h18, 32'h8, "R4 mask clear bit0");

      pulse(4'h3);
      @(negedge clk);
      check("R7 masked events no irq", DW'(irq), '0);
      rd(5'h1C, 32'h3, "R5 events 0011");
      rd(5'h1C, 32'h0, "R5 cleared by read");

      pulse(4'h8);
      check("R7 irq one cycle late", DW'(irq), '0);
      @(negedge clk);
      check("R7 irq raised", DW'(irq), 32'h1);
      rd(5'h1C, 32'h8, "R5 event 1000");
      @(negedge clk);
      check("R7 irq dropped after ack", DW'(irq), '0);

      pulse(4'h1);
      rd(5'h1C, 32'h1, "R6 read during pulse returns old", 4'h1);
      rd(5'h1C, 32'h1, "R6 same-cycle pulse kept");
      rd(5'h1C, 32'h4 & 32'h0, "R6 then empty", 4'h4);
      rd(5'h1C, 32'h4, "R6 pulse on empty latch kept");

      wr(5'h00, 32'hA5A5_1234);
      check("R9 mode_cfg", mode_cfg, 32'hA5A5_1234);
      rd(5'h00, 32'hA5A5_1234, "R9 mode readback");

      wr(5'h04, 32'h3);
      wr(5'h0C, 32'hF);
      check("R10 status write ignored", DW'(chan_run), 32'h3);
      wr(5'h18, 32'h7);
      rd(5'h18, 32'h8, "R10 mask write ignored");
      pulse(4'h2);
      wr(5'h1C, 32'hF);
      rd(5'h1C, 32'h2, "R10 event write ignored");
      rd(5'h04, 32'h0, "R10 enable reads zero");
      rd(5'h14, 32'h0, "R10 int-disable reads zero");
      wr(5'h05, 32'hF);
      check("R10 misaligned write ignored", DW'(chan_run), 32'h3);
      @(negedge clk);
      check("R11 rdata holds", bus_rdata, 32'h0);

      wr(5'h10, 32'hF);
      pulse(4'h4);
      @(negedge clk);
      check("R7 irq before reset", DW'(irq), 32'h1);
      do_reset();
      check("R8 run cleared", DW'(chan_run), '0);
      check("R8 irq cleared", DW'(irq), '0);
      check("R8 mode cleared", mode_cfg, '0);
      rd(5'h18, 32'h0, "R8 mask cleared");
      rd(5'h1C, 32'h0, "R8 events cleared");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) check("R11 reads left unanswered", DW'(exp_q.size()), '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule